// File: doc/BRIEF.md
# Redundant Thread Result Check Queue

This block sits beside a processor running one program as two redundant threads, a leading thread and a trailing thread. Each in-flight instruction owns a slot in a small queue. Both threads deliver the result of that instruction to its slot. The block pairs the two results, compares them, and keeps a verdict per slot that says whether the instruction may commit. Commit, pipeline flush and register renaming stay outside. The block only says which slots are ready to commit and which failed.

Either thread may deliver first. If the leading result is stored first, the trailing result is compared with it on arrival. If the trailing result is stored first, the leading result is compared with it, but the verdict is held back until the leading instruction signals that it has reached its fault-check stage. A failed verdict raises a recovery request that names the slot, so that execution can restart from that instruction.

The per-slot full/empty bit and verdict state are each kept as three copies. They are read by majority vote. If the copies disagree, the slot is reported as failed. A corrupted control bit therefore turns into a recovery rather than a pair that waits forever.

Top module: `result_check_queue`

## Requirements
- R1: After reset every slot is idle (code 00), no slot is commit-ready and no recovery request is raised.
- R2: Allocating a slot sets its state to not-checked-yet (code 01) in the cycle after the allocate strobe. State codes in `cvState[2*i+1:2*i]` are 00 idle, 01 not-checked-yet, 10 checked-ok, 11 failed-check.
- R3: When the leading result is stored first, a trailing result for the slot sets the state to checked-ok if the two values are equal and to failed-check otherwise, in the cycle after the trailing write.
- R4: When the trailing result reaches an empty slot, its value is stored and the slot stays not-checked-yet. The verdict is set only when the fault-check marker for the slot arrives, with the leading result already stored or arriving in the same cycle. A marker that arrives before the leading result has no effect.
- R5: `commitReady[i]` is 1 exactly when slot i is checked-ok. A slot holding one result, or two results that are not yet checked, is never ready.
- R6: `recoveryReq` is high while any slot is failed-check, and `recoverySlot` gives the lowest-numbered failed slot.
- R7: Releasing a slot returns it to idle in the next cycle and clears any failure it held.
- R8: A result write to a slot that is not in not-checked-yet has no effect. So does a second leading write to a slot that already holds a leading value.
- R9: Leading and trailing writes to the same empty slot in one cycle are compared with each other directly. A leading write together with the check marker on a slot that holds a trailing value gives the verdict in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate strobe |
| allocSlot | input | 4 | Slot to allocate |
| releaseValid | input | 1 | Release strobe, wins over allocate on the same slot |
| releaseSlot | input | 4 | Slot to release |
| leadValid | input | 1 | Leading thread result valid |
| leadSlot | input | 4 | Slot of the leading result |
| leadValue | input | 32 | Leading result value |
| trailValid | input | 1 | Trailing thread result valid |
| trailSlot | input | 4 | Slot of the trailing result |
| trailValue | input | 32 | Trailing result value |
| checkValid | input | 1 | Leading instruction reached its fault-check stage |
| checkSlot | input | 4 | Slot of that instruction |
| cvState | output | 32 | Two-bit commit state per slot |
| commitReady | output | 16 | One bit per slot, set when checked-ok |
| recoveryReq | output | 1 | Some slot failed its check |
| recoverySlot | output | 4 | Lowest failed slot |

## Verification
Every verdict is registered, so a wrong state in the control store shows on `cvState` and `commitReady` one cycle after the write or marker that caused it. A lost full bit shows the same way: a lead-first pair never leaves not-checked-yet, or a trailing value is stored instead of being compared. A slot whose verdict is never given stays blocked from commit, with no time limit. A wrong failed entry shows at once on `recoveryReq` and in the lowest-index `recoverySlot`. The bench therefore checks each slot state together with the ready bit and the recovery outputs after every operation.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    CV_IDLE = 2'b00,
    CV_WAIT = 2'b01,
    CV_OK   = 2'b10,
    CV_FAIL = 2'b11
  } cv_state_e;

  typedef struct packed {
    logic leadStore;
    logic trailStore;
  } cq_strobe_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/cq_datapath.sv
module cq_datapath
  import cq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int WIDTH = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cq_strobe_t       strobe,
  input  logic [SW-1:0]    leadSlot,
  input  logic [WIDTH-1:0] leadValue,
  input  logic [SW-1:0]    trailSlot,
  input  logic [WIDTH-1:0] trailValue,
  output logic             leadMatch,
  output logic             trailMatch,
  output logic             pairMatch
);

  logic [WIDTH-1:0] store [SLOTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) store[i] <= '0;
    end else begin
      if (strobe.leadStore)  store[leadSlot]  <= leadValue;
      if (strobe.trailStore) store[trailSlot] <= trailValue;
    end
  end

  assign leadMatch  = (store[leadSlot] == leadValue);
  assign trailMatch = (store[trailSlot] == trailValue);
  assign pairMatch  = (leadValue == trailValue);

endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [SW-1:0]      allocSlot,
  input  logic               releaseValid,
  input  logic [SW-1:0]      releaseSlot,
  input  logic               leadValid,
  input  logic [SW-1:0]      leadSlot,
  input  logic               trailValid,
  input  logic [SW-1:0]      trailSlot,
  input  logic               checkValid,
  input  logic [SW-1:0]      checkSlot,
  input  logic               leadMatch,
  input  logic               trailMatch,
  input  logic               pairMatch,
  output cq_strobe_t         strobe,
  output logic [2*SLOTS-1:0] stateVec,
  output logic [SLOTS-1:0]   commitReady,
  output logic               recoveryReq,
  output logic [SW-1:0]      recoverySlot
);

  // triplicated control store
  logic [2:0] fullQ [SLOTS];
  logic [1:0] stQ   [SLOTS][3];
  logic [SLOTS-1:0] ownTrailQ, pendValidQ, pendMatchQ;

  // voted view
  logic [SLOTS-1:0] fullV, copyBad;
  cv_state_e        stEff [SLOTS];

  // next state
  logic [SLOTS-1:0] nextFull, nextOwn, nextPendV, nextPendM;
  cv_state_e        nextSt [SLOTS];

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      logic [1:0] raw;
      fullV[i] = maj3(fullQ[i]);
      raw[0] = maj3({stQ[i][2][0], stQ[i][1][0], stQ[i][0][0]});
      raw[1] = maj3({stQ[i][2][1], stQ[i][1][1], stQ[i][0][1]});
      copyBad[i] = (fullQ[i] != 3'b000 && fullQ[i] != 3'b111) ||
                   (stQ[i][0] != stQ[i][1]) || (stQ[i][0] != stQ[i][2]);
      stEff[i] = copyBad[i] ? CV_FAIL : cv_state_e'(raw);
    end
  end

  always_comb begin
    strobe.leadStore  = leadValid && stEff[leadSlot] == CV_WAIT && !fullV[leadSlot];
    strobe.trailStore = trailValid && stEff[trailSlot] == CV_WAIT && !fullV[trailSlot] &&
                        !(strobe.leadStore && leadSlot == trailSlot);
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      logic leadHit, trailHit, chkHit;
      leadHit  = leadValid  && leadSlot  == SW'(i);
      trailHit = trailValid && trailSlot == SW'(i);
      chkHit   = checkValid && checkSlot == SW'(i);
      nextFull[i]  = fullV[i];
      nextOwn[i]   = ownTrailQ[i];
      nextPendV[i] = pendValidQ[i];
      nextPendM[i] = pendMatchQ[i];
      nextSt[i]    = stEff[i];
      if (releaseValid && releaseSlot == SW'(i)) begin
        nextFull[i] = 1'b0; nextOwn[i] = 1'b0; nextPendV[i] = 1'b0; nextPendM[i] = 1'b0;
        nextSt[i] = CV_IDLE;
      end else if (allocValid && allocSlot == SW'(i)) begin
        nextFull[i] = 1'b0; nextOwn[i] = 1'b0; nextPendV[i] = 1'b0; nextPendM[i] = 1'b0;
        nextSt[i] = CV_WAIT;
      end else if (stEff[i] == CV_WAIT) begin
        if (!fullV[i]) begin
          if (leadHit && trailHit) begin
            nextFull[i] = 1'b1; nextOwn[i] = 1'b0;
            nextSt[i] = pairMatch ? CV_OK : CV_FAIL;
          end else if (leadHit) begin
            nextFull[i] = 1'b1; nextOwn[i] = 1'b0;
          end else if (trailHit) begin
            nextFull[i] = 1'b1; nextOwn[i] = 1'b1;
          end
        end else if (!ownTrailQ[i]) begin
          if (trailHit) nextSt[i] = trailMatch ? CV_OK : CV_FAIL;
        end else begin
          if (leadHit && !pendValidQ[i]) begin
            nextPendV[i] = 1'b1; nextPendM[i] = leadMatch;
          end
          if (chkHit) begin
            if (pendValidQ[i])  nextSt[i] = pendMatchQ[i] ? CV_OK : CV_FAIL;
            else if (leadHit)   nextSt[i] = leadMatch ? CV_OK : CV_FAIL;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        fullQ[i] <= 3'b000;
        for (int c = 0; c < 3; c++) stQ[i][c] <= CV_IDLE;
      end
      ownTrailQ <= '0; pendValidQ <= '0; pendMatchQ <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        fullQ[i] <= {3{nextFull[i]}};
        for (int c = 0; c < 3; c++) stQ[i][c] <= nextSt[i];
      end
      ownTrailQ <= nextOwn; pendValidQ <= nextPendV; pendMatchQ <= nextPendM;
    end
  end

  always_comb begin
    recoveryReq  = 1'b0;
    recoverySlot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      stateVec[2*i +: 2] = stEff[i];
      commitReady[i]     = (stEff[i] == CV_OK);
      if (stEff[i] == CV_FAIL) begin
        recoveryReq  = 1'b1;
        recoverySlot = SW'(i);
      end
    end
  end

  AST_ALLOC_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && !(releaseValid && releaseSlot == allocSlot)
    |=> stateVec[2*$past(allocSlot) +: 2] == CV_WAIT); // R2

  AST_LEAD_FIRST_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    trailValid && stEff[trailSlot] == CV_WAIT && fullV[trailSlot] && !ownTrailQ[trailSlot] &&
    !(releaseValid && releaseSlot == trailSlot) && !(allocValid && allocSlot == trailSlot)
    |=> stateVec[2*$past(trailSlot) +: 2] != CV_WAIT); // R3

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |=> stateVec[2*$past(releaseSlot) +: 2] == CV_IDLE); // R7

  for (genvar g = 0; g < SLOTS; g++) begin : g_readyChk
    AST_READY_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(commitReady[g]) |->
      $past((trailValid && trailSlot == SW'(g)) || (checkValid && checkSlot == SW'(g)))); // R5
  end

endmodule

// File: rtl/result_check_queue.sv
module result_check_queue
  import cq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int WIDTH = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [SW-1:0]      allocSlot,
  input  logic               releaseValid,
  input  logic [SW-1:0]      releaseSlot,
  input  logic               leadValid,
  input  logic [SW-1:0]      leadSlot,
  input  logic [WIDTH-1:0]   leadValue,
  input  logic               trailValid,
  input  logic [SW-1:0]      trailSlot,
  input  logic [WIDTH-1:0]   trailValue,
  input  logic               checkValid,
  input  logic [SW-1:0]      checkSlot,
  output logic [2*SLOTS-1:0] cvState,
  output logic [SLOTS-1:0]   commitReady,
  output logic               recoveryReq,
  output logic [SW-1:0]      recoverySlot
);

  cq_strobe_t strobe;
  logic leadMatch, trailMatch, pairMatch;

  cq_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk, .rstN,
    .allocValid, .allocSlot, .releaseValid, .releaseSlot,
    .leadValid, .leadSlot, .trailValid, .trailSlot,
    .checkValid, .checkSlot,
    .leadMatch, .trailMatch, .pairMatch,
    .strobe,
    .stateVec(cvState), .commitReady, .recoveryReq, .recoverySlot
  );

  cq_datapath #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_dp (
    .clk, .rstN, .strobe,
    .leadSlot, .leadValue, .trailSlot, .trailValue,
    .leadMatch, .trailMatch, .pairMatch
  );

endmodule

// File: tb/result_check_queue_tb.sv
module result_check_queue_tb;
  localparam int SLOTS = 16;
  localparam int WIDTH = 32;
  localparam logic [1:0] ST_IDLE = 2'b00, ST_WAIT = 2'b01, ST_OK = 2'b10, ST_FAIL = 2'b11;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, releaseValid = 0, leadValid = 0, trailValid = 0, checkValid = 0;
  logic [3:0] allocSlot = 0, releaseSlot = 0, leadSlot = 0, trailSlot = 0, checkSlot = 0;
  logic [WIDTH-1:0] leadValue = 0, trailValue = 0;
  logic [2*SLOTS-1:0] cvState;
  logic [SLOTS-1:0] commitReady;
  logic recoveryReq;
  logic [3:0] recoverySlot;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    int slot; logic [1:0] st; logic req; int rslot; string tag;
  } exp_t;
  exp_t q[$];
  logic [1:0] expSt [SLOTS];

  always #10 clk = ~clk;

  result_check_queue u_dut (.*);

  task automatic clearIn();
    allocValid = 0; releaseValid = 0; leadValid = 0; trailValid = 0; checkValid = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clearIn();
  endtask

  task automatic doAlloc(input int s);   allocValid = 1; allocSlot = 4'(s); tick(); endtask
  task automatic doRelease(input int s); releaseValid = 1; releaseSlot = 4'(s); tick(); endtask
  task automatic doLead(input int s, input logic [WIDTH-1:0] v);
    leadValid = 1; leadSlot = 4'(s); leadValue = v; tick();
  endtask
  task automatic doTrail(input int s, input logic [WIDTH-1:0] v);
    trailValid = 1; trailSlot = 4'(s); trailValue = v; tick();
  endtask
  task automatic doCheck(input int s); checkValid = 1; checkSlot = 4'(s); tick(); endtask

  task automatic expectSlot(input int s, input logic [1:0] st, input string tag);
    exp_t e;
    expSt[s] = st;
    e.slot = s; e.st = st; e.req = 0; e.rslot = 0; e.tag = tag;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (expSt[i] == ST_FAIL) begin e.req = 1; e.rslot = i; end
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      logic [1:0] aSt;
      wait (q.size() != 0);
      e = q.pop_front();
      aSt = cvState[2*e.slot +: 2];
      checks++;
      if (aSt !== e.st || commitReady[e.slot] !== (e.st == ST_OK) ||
          recoveryReq !== e.req || (e.req && recoverySlot !== 4'(e.rslot))) begin
        errors++;
        $display("FAIL %s slot %0d: got st=%0d ready=%0b req=%0b rslot=%0d, expected st=%0d ready=%0b req=%0b rslot=%0d",
                 e.tag, e.slot, aSt, commitReady[e.slot], recoveryReq, recoverySlot,
                 e.st, (e.st == ST_OK), e.req, e.rslot);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < SLOTS; i++) expSt[i] = ST_IDLE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < SLOTS; i++) expectSlot(i, ST_IDLE, "R1 reset");

    doAlloc(2);          expectSlot(2, ST_WAIT, "R2 alloc");
    doLead(2, 32'hDEAD_0001); expectSlot(2, ST_WAIT, "R5 lead only not ready");
    doTrail(2, 32'hDEAD_0001); expectSlot(2, ST_OK, "R3 match");

    doAlloc(5);
    doLead(5, 32'h1234_5678);
    doTrail(5, 32'h1234_5679); expectSlot(5, ST_FAIL, "R3 mismatch, R6 request");

    doAlloc(9);
    doTrail(9, 32'hCAFE_0009); expectSlot(9, ST_WAIT, "R4 trailing stored");
    doCheck(9);          expectSlot(9, ST_WAIT, "R4 marker before lead");
    doLead(9, 32'hCAFE_0009); expectSlot(9, ST_WAIT, "R4 verdict deferred");
    doCheck(9);          expectSlot(9, ST_OK, "R4 verdict on marker");

    doAlloc(3);
    doTrail(3, 32'h0000_00D0);
    doLead(3, 32'h0000_00E0);
    doCheck(3);          expectSlot(3, ST_FAIL, "R6 lowest failed slot");

    doRelease(3);        expectSlot(3, ST_IDLE, "R7 release clears fail");
    doTrail(3, 32'h0000_00D0); expectSlot(3, ST_IDLE, "R8 idle slot ignores write");

    doAlloc(7);
    doLead(7, 32'h7777_0000);
    doLead(7, 32'h7777_FFFF);
    doTrail(7, 32'h7777_0000); expectSlot(7, ST_OK, "R8 second lead ignored");
    doTrail(2, 32'h0BAD_0BAD); expectSlot(2, ST_OK, "R8 decided slot ignores write");

    doAlloc(12);
    leadValid = 1; leadSlot = 4'd12; leadValue = 32'hF00D_F00D;
    trailValid = 1; trailSlot = 4'd12; trailValue = 32'hF00D_F00D;
    tick();              expectSlot(12, ST_OK, "R9 same-cycle pair match");

    doAlloc(13);
    leadValid = 1; leadSlot = 4'd13; leadValue = 32'h0000_0013;
    trailValid = 1; trailSlot = 4'd13; trailValue = 32'h0000_0031;
    tick();              expectSlot(13, ST_FAIL, "R9 same-cycle pair mismatch");

    doAlloc(14);
    doTrail(14, 32'h1414_1414);
    leadValid = 1; leadSlot = 4'd14; leadValue = 32'h1414_1414;
    checkValid = 1; checkSlot = 4'd14;
    tick();              expectSlot(14, ST_OK, "R9 lead with marker");

    doRelease(5);        expectSlot(5, ST_IDLE, "R7 release, R6 next failed");
    doRelease(13);       expectSlot(13, ST_IDLE, "R7 release last failure");
    doAlloc(2);          expectSlot(2, ST_WAIT, "R2 realloc decided slot");

    wait (q.size() == 0);
    #1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule